// File: doc/BRIEF.md
# Indexed CMOS Register File

This block is the byte-wide configuration store of a real-time-clock companion. It holds a bank of byte registers behind a pair of host I/O addresses. The host first writes a register number to the index address. After that, every access to the data address reaches the register that number selects, until a new number is written.

Each byte carries a bit that records whether anything has ever written it. A data read of a byte whose bit is still clear returns zero and raises an error indication. The four clock status bytes come out of reset with fixed values and already marked as written.

Reading the first status byte inverts its update-in-progress bit after the value is returned. A host that polls that bit therefore sees it change state on every read.

A side port lets the time-keeping logic read any byte at once and write bytes in the same clock domain. When a side write collides with a host access to the same byte, the host access wins.

Top module: `cmos_regfile`

## Requirements
- R1: After reset the latched index is 0, `io_rvalid` is low, and bytes 0x0A, 0x0B, 0x0C and 0x0D hold 0x26, 0x06, 0x00 and 0x80. All four read back without error, and every other byte is unwritten.
- R2: A write with `io_addr` = 0x70 latches `io_wdata` as the index, and later data accesses use it. The index address is write-only: a read there returns 0x00 with `io_rerr` low and leaves the index unchanged.
- R3: A write with `io_addr` = 0x71 stores `io_wdata` at the latched index and marks that byte written. A read with `io_addr` = 0x71 returns the byte on `io_rdata`, with `io_rvalid` high exactly one cycle after the strobe and `io_rerr` low.
- R4: A data read of a byte that has never been written returns 0x00 with `io_rerr` high.
- R5: A data read at index 0x0A returns the byte's current value. On the same edge, bit 7 of that byte is inverted and the other bits are kept.
- R6: With `tk_we` high, `tk_wdata` is stored at `tk_addr` and that byte is marked written. `tk_rdata` always shows the current content of byte `tk_addr` with no clock delay.
- R7: In a cycle where a host data write and a side write hit the same byte, the host value is kept. When they hit different bytes, both are stored.
- R8: In a cycle where a host data read at index 0x0A coincides with a side write to 0x0A, the side write is dropped and the bit 7 inversion is applied.
- R9: Strobes at any address other than 0x70 and 0x71 change no state and produce no `io_rvalid`.
- R10: When `io_wr` and `io_rd` are both high, only the write takes effect and no `io_rvalid` follows.
- R11: `io_rvalid` is a one-cycle pulse for each accepted read strobe and is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | AW | Host I/O address |
| io_wr | input | 1 | Host write strobe |
| io_rd | input | 1 | Host read strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Registered host read data |
| io_rvalid | output | 1 | Read data valid, one cycle after a read strobe |
| io_rerr | output | 1 | Read hit an unwritten byte |
| tk_we | input | 1 | Side-port write enable |
| tk_addr | input | IDX_W | Side-port byte number |
| tk_wdata | input | 8 | Side-port write data |
| tk_rdata | output | 8 | Side-port read data, combinational |

## Verification
The bench builds the block with its default parameters: a 256-byte bank, host addresses 0x70 and 0x71, and the status group based at 0x0A. With these values, the top index 0xFF and all four reset defaults can be reached directly. It also runs both collision orderings on the status byte and on ordinary bytes, so the same-cycle priority rules are exercised at a real address rather than at a scaled-down copy.

// File: rtl/cmos_regfile_pkg.sv
package cmos_regfile_pkg;

  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // Value a location takes at reset; the status group sits at base..base+3.
  function automatic byte_t boot_value(int unsigned loc, int unsigned base);
    byte_t v;
    v = 8'h00;
    if (loc == base)          v = 8'h26;
    else if (loc == base + 1) v = 8'h06;
    else if (loc == base + 2) v = 8'h00;
    else if (loc == base + 3) v = 8'h80;
    return v;
  endfunction

  // Whether a location counts as written right after reset.
  function automatic logic boot_valid(int unsigned loc, int unsigned base);
    return (loc >= base) && (loc <= base + 3);
  endfunction

  // Invert a single bit of a byte.
  function automatic byte_t flip_bit(byte_t b, int unsigned pos);
    byte_t m;
    m = byte_t'(1) << pos;
    return b ^ m;
  endfunction

  // Read response data: zero when the byte was never written.
  function automatic byte_t masked_read(byte_t b, logic written);
    return written ? b : 8'h00;
  endfunction

endpackage

// File: rtl/cmos_port_decode.sv
module cmos_port_decode #(
  parameter int unsigned AW       = 8,
  parameter int unsigned IDX_PORT = 'h70,
  parameter int unsigned DAT_PORT = 'h71
) (
  input  logic [AW-1:0] io_addr,
  input  logic          io_wr,
  input  logic          io_rd,
  output logic          idx_wr_evt,
  output logic          idx_rd_evt,
  output logic          dat_wr_evt,
  output logic          dat_rd_evt
);

  logic at_idx;
  logic at_dat;
  logic rd_only;

  assign at_idx  = (io_addr == AW'(IDX_PORT));
  assign at_dat  = (io_addr == AW'(DAT_PORT));
  assign rd_only = io_rd && !io_wr;

  assign idx_wr_evt = io_wr && at_idx;
  assign dat_wr_evt = io_wr && at_dat;
  assign idx_rd_evt = rd_only && at_idx;
  assign dat_rd_evt = rd_only && at_dat;

endmodule

// File: rtl/cmos_index_latch.sv
module cmos_index_latch #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  output logic [IDX_W-1:0] idx_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (load) begin
      idx_q <= load_val;
    end
  end

endmodule

// File: rtl/cmos_byte_store.sv
module cmos_byte_store
  import cmos_regfile_pkg::*;
#(
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned DEPTH      = 256,
  parameter int unsigned STAT_A_IDX = 'h0A,
  parameter int unsigned UIP_BIT    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] host_idx,
  input  logic             host_we,
  input  logic             host_rd,
  input  byte_t            host_wdata,
  input  logic             side_we,
  input  logic [IDX_W-1:0] side_addr,
  input  byte_t            side_wdata,
  output byte_t            host_byte,
  output logic             host_valid,
  output byte_t            side_byte,
  output byte_t            stat_a_byte,
  output logic             flip_req,
  output logic             side_drop
);

  byte_t [DEPTH-1:0] mem_w;
  logic  [DEPTH-1:0] vld_w;

  // The status byte flips only on a read that actually returns its value.
  assign flip_req  = host_rd && (host_idx == IDX_W'(STAT_A_IDX)) && vld_w[STAT_A_IDX];
  // The host owns a byte it touches this cycle; the side write to it is lost.
  assign side_drop = side_we &&
                     ((host_we && (side_addr == host_idx)) ||
                      (flip_req && (side_addr == IDX_W'(STAT_A_IDX))));

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    byte_t cell_q;
    logic  cell_v;
    logic  hw;
    logic  sw;
    logic  fl;

    assign hw = host_we && (host_idx == IDX_W'(g));
    assign sw = side_we && !side_drop && (side_addr == IDX_W'(g));
    assign fl = flip_req && (STAT_A_IDX == g);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q <= boot_value(g, STAT_A_IDX);
        cell_v <= boot_valid(g, STAT_A_IDX);
      end else if (hw) begin
        cell_q <= host_wdata;
        cell_v <= 1'b1;
      end else if (fl) begin
        cell_q <= flip_bit(cell_q, UIP_BIT);
      end else if (sw) begin
        cell_q <= side_wdata;
        cell_v <= 1'b1;
      end
    end

    assign mem_w[g] = cell_q;
    assign vld_w[g] = cell_v;
  end

  assign host_byte   = mem_w[host_idx];
  assign host_valid  = vld_w[host_idx];
  assign side_byte   = mem_w[side_addr];
  assign stat_a_byte = mem_w[STAT_A_IDX];

endmodule

// File: rtl/cmos_rd_resp.sv
module cmos_rd_resp
  import cmos_regfile_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  dat_rd_evt,
  input  logic  idx_rd_evt,
  input  byte_t host_byte,
  input  logic  host_valid,
  output byte_t rdata,
  output logic  rvalid,
  output logic  rerr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= 8'h00;
      rvalid <= 1'b0;
      rerr   <= 1'b0;
    end else begin
      rvalid <= dat_rd_evt || idx_rd_evt;
      rdata  <= dat_rd_evt ? masked_read(host_byte, host_valid) : 8'h00;
      rerr   <= dat_rd_evt && !host_valid;
    end
  end

endmodule

// File: rtl/cmos_regfile.sv
module cmos_regfile
  import cmos_regfile_pkg::*;
#(
  parameter int unsigned AW         = 8,
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned IDX_PORT   = 'h70,
  parameter int unsigned DAT_PORT   = 'h71,
  parameter int unsigned STAT_A_IDX = 'h0A,
  parameter int unsigned UIP_BIT    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    io_addr,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [7:0]       io_wdata,
  output logic [7:0]       io_rdata,
  output logic             io_rvalid,
  output logic             io_rerr,
  input  logic             tk_we,
  input  logic [IDX_W-1:0] tk_addr,
  input  logic [7:0]       tk_wdata,
  output logic [7:0]       tk_rdata
);

  localparam int unsigned DEPTH = 1 << IDX_W;

  logic             idx_wr_evt;
  logic             idx_rd_evt;
  logic             dat_wr_evt;
  logic             dat_rd_evt;
  logic [IDX_W-1:0] idx_q;
  byte_t            host_byte;
  logic             host_valid;
  byte_t            stat_a_byte;
  logic             flip_req;
  logic             side_drop;

  cmos_port_decode #(
    .AW(AW), .IDX_PORT(IDX_PORT), .DAT_PORT(DAT_PORT)
  ) u_dec (
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .idx_wr_evt(idx_wr_evt), .idx_rd_evt(idx_rd_evt),
    .dat_wr_evt(dat_wr_evt), .dat_rd_evt(dat_rd_evt)
  );

  cmos_index_latch #(.IDX_W(IDX_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .load(idx_wr_evt),
    .load_val(io_wdata[IDX_W-1:0]), .idx_q(idx_q)
  );

  cmos_byte_store #(
    .IDX_W(IDX_W), .DEPTH(DEPTH), .STAT_A_IDX(STAT_A_IDX), .UIP_BIT(UIP_BIT)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .host_idx(idx_q), .host_we(dat_wr_evt), .host_rd(dat_rd_evt),
    .host_wdata(io_wdata),
    .side_we(tk_we), .side_addr(tk_addr), .side_wdata(tk_wdata),
    .host_byte(host_byte), .host_valid(host_valid),
    .side_byte(tk_rdata), .stat_a_byte(stat_a_byte),
    .flip_req(flip_req), .side_drop(side_drop)
  );

  cmos_rd_resp u_resp (
    .clk(clk), .rst_n(rst_n),
    .dat_rd_evt(dat_rd_evt), .idx_rd_evt(idx_rd_evt),
    .host_byte(host_byte), .host_valid(host_valid),
    .rdata(io_rdata), .rvalid(io_rvalid), .rerr(io_rerr)
  );

endmodule

// File: rtl/cmos_regfile_chk.sv
module cmos_regfile_chk #(
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned STAT_A_IDX = 'h0A,
  parameter int unsigned UIP_BIT    = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             io_wr,
  input logic             io_rd,
  input logic [7:0]       io_wdata,
  input logic [7:0]       io_rdata,
  input logic             io_rvalid,
  input logic             io_rerr,
  input logic             tk_we,
  input logic [IDX_W-1:0] tk_addr,
  input logic             idx_wr_evt,
  input logic             idx_rd_evt,
  input logic             dat_wr_evt,
  input logic             dat_rd_evt,
  input logic [IDX_W-1:0] idx_q,
  input logic [7:0]       host_byte,
  input logic             host_valid,
  input logic [7:0]       stat_a_byte
);

  p_rvalid_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd_evt || idx_rd_evt) |=> io_rvalid);

  p_rvalid_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(dat_rd_evt || idx_rd_evt) |=> !io_rvalid);

  p_err_zero_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    io_rerr |-> (io_rvalid && io_rdata == 8'h00));

  p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr_evt |=> (host_valid && host_byte == $past(io_wdata)));

  p_host_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr_evt && tk_we && tk_addr == idx_q) |=> (host_byte == $past(io_wdata)));

  p_uip_flips_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd_evt && idx_q == IDX_W'(STAT_A_IDX) && host_valid) |=>
      (stat_a_byte[UIP_BIT] != $past(stat_a_byte[UIP_BIT])));

  p_index_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_wr_evt |=> $stable(idx_q));

  p_write_over_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_rd) |=> !io_rvalid);

endmodule

bind cmos_regfile cmos_regfile_chk #(
  .IDX_W(IDX_W), .STAT_A_IDX(STAT_A_IDX), .UIP_BIT(UIP_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
  .io_rerr(io_rerr), .tk_we(tk_we), .tk_addr(tk_addr),
  .idx_wr_evt(idx_wr_evt), .idx_rd_evt(idx_rd_evt),
  .dat_wr_evt(dat_wr_evt), .dat_rd_evt(dat_rd_evt),
  .idx_q(idx_q), .host_byte(host_byte), .host_valid(host_valid),
  .stat_a_byte(stat_a_byte)
);

// File: tb/sim_cmos_regfile.sv
`timescale 1ns/1ps
module sim_cmos_regfile;

  localparam logic [7:0] IDXP = 8'h70;
  localparam logic [7:0] DATP = 8'h71;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] io_addr = 8'h00;
  logic       io_wr = 1'b0;
  logic       io_rd = 1'b0;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] io_rdata;
  logic       io_rvalid;
  logic       io_rerr;
  logic       tk_we = 1'b0;
  logic [7:0] tk_addr = 8'h00;
  logic [7:0] tk_wdata = 8'h00;
  logic [7:0] tk_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cmos_regfile u0 (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
    .io_rerr(io_rerr), .tk_we(tk_we), .tk_addr(tk_addr),
    .tk_wdata(tk_wdata), .tk_rdata(tk_rdata)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic set_index(input logic [7:0] i);
    @(negedge clk); io_addr = IDXP; io_wdata = i; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic data_write(input logic [7:0] d);
    @(negedge clk); io_addr = DATP; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic port_read(input logic [7:0] a, output logic [7:0] d,
                           output logic e, output logic v);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    @(negedge clk); io_rd = 1'b0;
    d = io_rdata; e = io_rerr; v = io_rvalid;
  endtask

  task automatic side_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); tk_addr = a; tk_wdata = d; tk_we = 1'b1;
    @(negedge clk); tk_we = 1'b0;
  endtask

  task automatic side_peek(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); tk_addr = a;
    #1 d = tk_rdata;
  endtask

  task automatic expect_read(input string req, input logic [7:0] exp_d, input logic exp_e);
    logic [7:0] d; logic e; logic v;
    port_read(DATP, d, e, v);
    chk(req, "rvalid", v, 1);
    chk(req, "rdata", d, exp_d);
    chk(req, "rerr", e, exp_e);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1", "rvalid idle", io_rvalid, 0);
    expect_read("R1", 8'h00, 1'b1);     // index 0 is unwritten
    set_index(8'h0B); expect_read("R1", 8'h06, 1'b0);
    set_index(8'h0C); expect_read("R1", 8'h00, 1'b0);
    set_index(8'h0D); expect_read("R1", 8'h80, 1'b0);
    side_peek(8'h0A, d); chk("R1", "status A default", d, 8'h26);
  endtask

  task automatic t_write_read;
    set_index(8'h20); data_write(8'h55); expect_read("R3", 8'h55, 1'b0);
    @(negedge clk); chk("R11", "rvalid drops", io_rvalid, 0);
    set_index(8'hFF); data_write(8'hAA); expect_read("R3", 8'hAA, 1'b0);
  endtask

  task automatic t_unwritten;
    set_index(8'h33); expect_read("R4", 8'h00, 1'b1);
    set_index(8'h01); expect_read("R4", 8'h00, 1'b1);
  endtask

  task automatic t_index_port;
    logic [7:0] d; logic e; logic v;
    set_index(8'h20);
    port_read(IDXP, d, e, v);
    chk("R2", "index read rvalid", v, 1);
    chk("R2", "index read data", d, 8'h00);
    chk("R2", "index read rerr", e, 0);
    expect_read("R2", 8'h55, 1'b0);
  endtask

  task automatic t_status_flip;
    logic [7:0] d;
    set_index(8'h0A);
    expect_read("R5", 8'h26, 1'b0);
    side_peek(8'h0A, d); chk("R5", "after first read", d, 8'hA6);
    expect_read("R5", 8'hA6, 1'b0);
    side_peek(8'h0A, d); chk("R5", "after second read", d, 8'h26);
  endtask

  task automatic t_side;
    logic [7:0] d;
    side_write(8'h40, 8'h9C);
    side_peek(8'h40, d); chk("R6", "side readback", d, 8'h9C);
    set_index(8'h40); expect_read("R6", 8'h9C, 1'b0);
  endtask

  task automatic t_collide;
    logic [7:0] d;
    set_index(8'h50);
    @(negedge clk);
    io_addr = DATP; io_wdata = 8'h11; io_wr = 1'b1;
    tk_addr = 8'h50; tk_wdata = 8'h22; tk_we = 1'b1;
    @(negedge clk); io_wr = 1'b0; tk_we = 1'b0;
    expect_read("R7", 8'h11, 1'b0);
    @(negedge clk);
    io_addr = DATP; io_wdata = 8'h33; io_wr = 1'b1;
    tk_addr = 8'h60; tk_wdata = 8'h44; tk_we = 1'b1;
    @(negedge clk); io_wr = 1'b0; tk_we = 1'b0;
    expect_read("R7", 8'h33, 1'b0);
    side_peek(8'h60, d); chk("R7", "other byte stored", d, 8'h44);
  endtask

  task automatic t_status_collide;
    logic [7:0] d;
    set_index(8'h0A);
    @(negedge clk);
    io_addr = DATP; io_rd = 1'b1;
    tk_addr = 8'h0A; tk_wdata = 8'h00; tk_we = 1'b1;
    @(negedge clk); io_rd = 1'b0; tk_we = 1'b0;
    chk("R8", "read value", io_rdata, 8'h26);
    side_peek(8'h0A, d); chk("R8", "side write dropped", d, 8'hA6);
  endtask

  task automatic t_undecoded;
    logic [7:0] d; logic e; logic v;
    set_index(8'h20);
    @(negedge clk); io_addr = 8'h72; io_wdata = 8'h77; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
    port_read(8'h72, d, e, v);
    chk("R9", "no rvalid", v, 0);
    expect_read("R9", 8'h55, 1'b0);
  endtask

  task automatic t_both_strobes;
    set_index(8'h21);
    @(negedge clk); io_addr = DATP; io_wdata = 8'h5A; io_wr = 1'b1; io_rd = 1'b1;
    @(negedge clk); io_wr = 1'b0; io_rd = 1'b0;
    chk("R10", "no rvalid", io_rvalid, 0);
    expect_read("R10", 8'h5A, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_read();
    t_unwritten();
    t_index_port();
    t_status_flip();
    t_side();
    t_collide();
    t_status_collide();
    t_undecoded();
    t_both_strobes();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule